// File: doc/BRIEF.md
# Memory Operand Effective Address Generator

This block turns the addressing byte of a memory-operand instruction, plus whatever scale/index/base byte and displacement bytes follow it, into a 32-bit effective offset. A caller presents the addressing byte with a `start` strobe while the block is idle. Any trailing bytes are then pulled one at a time from a byte stream with a valid/ready handshake. Base and index values come from an external eight-entry register file through a single combinational read port.

When the offset is ready, the block pulses `done` for one cycle. Alongside it, the block presents three results: the offset, how many stream bytes it consumed, and a flag for encodings that cannot describe a memory operand. Segment bases, limits and the memory access itself belong to other logic.

Addressing byte fields: `mod` = bits 7:6, `rm` = bits 2:0, bits 5:3 are not used for addressing. Scale/index/base byte fields: `scale` = bits 7:6, `index` = bits 5:3, `base` = bits 2:0.

Top module: `modrm_ea_unit`

## Requirements
- R1: `mod`=3 completes with `bad_form`=1, `offset`=0 and `used_bytes`=0, and consumes no stream bytes.
- R2: With `rm`≠4 and not (`mod`=0, `rm`=5), the offset is register[`rm`] plus the displacement (none for `mod`=0, one byte for `mod`=1, four bytes for `mod`=2).
- R3: `mod`=0 with `rm`=5 gives an offset equal to a four-byte displacement alone, with no register added.
- R4: `rm`=4 with `mod`≠3 consumes one scale/index/base byte from the stream before any displacement bytes, and that byte is counted in `used_bytes`.
- R5: In the scale/index/base form, `base`=5 with `mod`=0 adds no base register and adds a four-byte displacement instead.
- R6: `index`=4 adds no index term, and a nonzero `scale` together with `index`=4 sets `bad_form`=1. The operation still consumes its displacement and completes.
- R7: The index register value is shifted left by `scale` (multiplied by 1, 2, 4 or 8) before it is added, with 32-bit wraparound.
- R8: Displacement bytes arrive least significant first, and a one-byte displacement is sign-extended to 32 bits.
- R9: `done` is high for exactly one cycle per operation, and `offset`, `used_bytes` and `bad_form` hold their values until the next `done`.
- R10: `start` is ignored while `idle` is low, and `byte_ready` is low whenever `idle` is high.
- R11: `used_bytes` equals the number of stream handshakes in the operation, never more than 5.
- R12: After reset, `idle`=1, while `done`, `byte_ready`, `offset`, `used_bytes` and `bad_form` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation with `modrm` (taken only while idle) |
| modrm | input | 8 | Addressing byte |
| idle | output | 1 | Block can accept `start` |
| byte_valid | input | 1 | Stream byte present |
| byte_data | input | 8 | Stream byte |
| byte_ready | output | 1 | Block takes the stream byte this cycle if valid |
| rf_sel | output | 3 | Register file read select |
| rf_rdata | input | 32 | Register file read data for `rf_sel` (same cycle) |
| done | output | 1 | One-cycle completion pulse |
| offset | output | 32 | Effective offset |
| used_bytes | output | 3 | Stream bytes consumed by the last operation |
| bad_form | output | 1 | Encoding is not a valid memory operand |

## Verification
The hardest case to reach from the ports is an illegal scale paired with the no-index code, in an operation that still has to drain its displacement. The same goes for the no-base escape, which only means "no base" under `mod`=0. The bench reaches both by sweeping every scale/index/base byte under each of the three memory `mod` values. It compares each result with arithmetic on its own register model.

Stalls and a busy block are reached separately. Valid gaps are inserted in the stream, and some operations hold `start` high with an illegal addressing byte for as long as the block is busy.

// File: rtl/ea_pkg.sv
package ea_pkg;

   localparam int FIELD_W = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SIB,
      ST_BASE,
      ST_INDEX,
      ST_DISP,
      ST_FIN
   } ea_state_e;

   typedef struct packed {
      logic               has_base;
      logic [FIELD_W-1:0] base_sel;
      logic               has_index;
      logic [FIELD_W-1:0] index_sel;
      logic [1:0]         scale;
      logic [2:0]         disp_len;
      logic               bad_scale;
   } ea_plan_t;

endpackage

// File: rtl/ea_decode.sv
module ea_decode
   import ea_pkg::*;
(
   input  logic [1:0]         mode,
   input  logic [FIELD_W-1:0] rm,
   input  logic [7:0]         sib,
   output logic               needs_sib,
   output logic               mode_bad,
   output ea_plan_t           plan
);

   logic [1:0]         ss;
   logic [FIELD_W-1:0] ix;
   logic [FIELD_W-1:0] bs;

   assign ss = sib[7:6];
   assign ix = sib[5:3];
   assign bs = sib[2:0];

   always_comb begin
      plan      = '0;
      mode_bad  = (mode == 2'd3);
      needs_sib = (rm == 3'd4) && !mode_bad;
      unique case (mode)
         2'd1:    plan.disp_len = 3'd1;
         2'd2:    plan.disp_len = 3'd4;
         default: plan.disp_len = 3'd0;
      endcase
      if (needs_sib) begin
         plan.has_base  = !((mode == 2'd0) && (bs == 3'd5));
         plan.base_sel  = bs;
         plan.has_index = (ix != 3'd4);
         plan.index_sel = ix;
         plan.scale     = ss;
         plan.bad_scale = (ix == 3'd4) && (ss != 2'd0);
         if ((mode == 2'd0) && (bs == 3'd5)) plan.disp_len = 3'd4;
      end else begin
         plan.has_base = !((mode == 2'd0) && (rm == 3'd5)) && !mode_bad;
         plan.base_sel = rm;
         if ((mode == 2'd0) && (rm == 3'd5)) plan.disp_len = 3'd4;
      end
   end

   always_comb begin
      assert (!(plan.bad_scale && plan.has_index))
         else $error("assert_bad_scale_no_index_R6");
   end

endmodule

// File: rtl/ea_disp_collect.sv
module ea_disp_collect #(
   parameter int LANES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               take,
   input  logic [7:0]         data,
   input  logic [2:0]         len,
   output logic [LANES*8-1:0] disp,
   output logic               last
);

   localparam int WORD_W = LANES * 8;
   localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;

   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] word;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  lane_q <= '0;
         else if (clear)                              lane_q <= '0;
         else if (take && (idx == IDX_W'(g)))         lane_q <= data;
      end
      assign word[g*8 +: 8] = lane_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx <= '0;
      else if (clear) idx <= '0;
      else if (take)  idx <= idx + IDX_W'(1);
   end

   assign last = take && ((32'(idx) + 32'd1) == 32'(len));
   assign disp = (len == 3'd1) ? {{(WORD_W-8){word[7]}}, word[7:0]} : word;

   assert_take_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (32'(idx) < 32'(len)));

endmodule

// File: rtl/ea_scaler.sv
module ea_scaler #(
   parameter int ADDR_W       = 32,
   parameter bit SCALE_BY_MUX = 1'b1
) (
   input  logic [ADDR_W-1:0] value,
   input  logic [1:0]        scale,
   input  logic              en,
   output logic [ADDR_W-1:0] scaled
);

   logic [ADDR_W-1:0] shifted;

   if (SCALE_BY_MUX) begin : g_mux
      always_comb begin
         unique case (scale)
            2'd0: shifted = value;
            2'd1: shifted = {value[ADDR_W-2:0], 1'b0};
            2'd2: shifted = {value[ADDR_W-3:0], 2'b0};
            default: shifted = {value[ADDR_W-4:0], 3'b0};
         endcase
      end
   end else begin : g_shift
      assign shifted = value << scale;
   end

   assign scaled = en ? shifted : '0;

endmodule

// File: rtl/modrm_ea_unit.sv
module modrm_ea_unit
   import ea_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int NREG         = 8,
   parameter bit SCALE_BY_MUX = 1'b1,
   localparam int SEL_W       = $clog2(NREG),
   localparam int LANES       = ADDR_W / 8,
   localparam int CNT_W       = $clog2(LANES + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        modrm,
   output logic              idle,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   output logic              byte_ready,
   output logic [SEL_W-1:0]  rf_sel,
   input  logic [ADDR_W-1:0] rf_rdata,
   output logic              done,
   output logic [ADDR_W-1:0] offset,
   output logic [CNT_W-1:0]  used_bytes,
   output logic              bad_form
);

   if (ADDR_W != 32) begin : g_bad_width
      $error("modrm_ea_unit: ADDR_W must be 32");
   end
   if (NREG != 8) begin : g_bad_regs
      $error("modrm_ea_unit: NREG must be 8");
   end

   ea_state_e         state;
   logic [1:0]        mode_q;
   logic [2:0]        rm_q;
   logic [7:0]        sib_q;
   logic [ADDR_W-1:0] acc;
   logic [CNT_W-1:0]  cnt;

   logic              done_q;
   logic [ADDR_W-1:0] offset_q;
   logic [CNT_W-1:0]  count_q;
   logic              bad_q;

   logic              needs_sib;
   logic              mode_bad;
   ea_plan_t          plan;
   logic [ADDR_W-1:0] disp;
   logic              disp_last;
   logic [ADDR_W-1:0] scaled_idx;
   logic              take_byte;
   logic              accept;
   logic [CNT_W-1:0]  exp_cnt;
   logic              unused_reg_field;

   assign unused_reg_field = ^modrm[5:3];

   ea_decode u_decode (
      .mode      (mode_q),
      .rm        (rm_q),
      .sib       (sib_q),
      .needs_sib (needs_sib),
      .mode_bad  (mode_bad),
      .plan      (plan)
   );

   ea_disp_collect #(.LANES(LANES)) u_disp (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .take  (take_byte && (state == ST_DISP)),
      .data  (byte_data),
      .len   (plan.disp_len),
      .disp  (disp),
      .last  (disp_last)
   );

   ea_scaler #(.ADDR_W(ADDR_W), .SCALE_BY_MUX(SCALE_BY_MUX)) u_scale (
      .value  (rf_rdata),
      .scale  (plan.scale),
      .en     (plan.has_index),
      .scaled (scaled_idx)
   );

   assign idle       = (state == ST_IDLE);
   assign accept     = idle && start;
   assign byte_ready = (state == ST_SIB) || (state == ST_DISP);
   assign take_byte  = byte_valid && byte_ready;
   assign exp_cnt    = CNT_W'(needs_sib) + CNT_W'(plan.disp_len);

   always_comb begin
      unique case (state)
         ST_BASE:  rf_sel = SEL_W'(plan.base_sel);
         ST_INDEX: rf_sel = SEL_W'(plan.index_sel);
         default:  rf_sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mode_q   <= '0;
         rm_q     <= '0;
         sib_q    <= '0;
         acc      <= '0;
         cnt      <= '0;
         done_q   <= 1'b0;
         offset_q <= '0;
         count_q  <= '0;
         bad_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  mode_q <= modrm[7:6];
                  rm_q   <= modrm[2:0];
                  sib_q  <= '0;
                  acc    <= '0;
                  cnt    <= '0;
                  if (modrm[7:6] == 2'd3)      state <= ST_FIN;
                  else if (modrm[2:0] == 3'd4) state <= ST_SIB;
                  else                         state <= ST_BASE;
               end
            end
            ST_SIB: begin
               if (take_byte) begin
                  sib_q <= byte_data;
                  cnt   <= cnt + CNT_W'(1);
                  state <= ST_BASE;
               end
            end
            ST_BASE: begin
               acc   <= plan.has_base ? rf_rdata : '0;
               state <= ST_INDEX;
            end
            ST_INDEX: begin
               acc   <= acc + scaled_idx;
               state <= (plan.disp_len != 3'd0) ? ST_DISP : ST_FIN;
            end
            ST_DISP: begin
               if (take_byte) begin
                  cnt <= cnt + CNT_W'(1);
                  if (disp_last) state <= ST_FIN;
               end
            end
            ST_FIN: begin
               offset_q <= mode_bad ? '0 :
                           (acc + ((plan.disp_len != 3'd0) ? disp : '0));
               count_q  <= cnt;
               bad_q    <= mode_bad || (needs_sib && plan.bad_scale);
               done_q   <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done       = done_q;
   assign offset     = offset_q;
   assign used_bytes = count_q;
   assign bad_form   = bad_q;

   assert_mode3_flagged_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FIN && mode_bad) |=> (done && bad_form && offset == '0 && used_bytes == '0));

   assert_sib_counted_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FIN && needs_sib) |=> (used_bytes != '0));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(offset) && $stable(used_bytes) && $stable(bad_form)));

   assert_no_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !byte_ready);

   assert_count_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FIN && !mode_bad) |=> (used_bytes == $past(exp_cnt)));

   assert_count_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      used_bytes <= CNT_W'(LANES + 1));

endmodule

// File: tb/tb_modrm_ea_unit.sv
module tb_modrm_ea_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  modrm = '0;
   logic        idle;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        byte_ready;
   logic [2:0]  rf_sel;
   logic [31:0] rf_rdata;
   logic        done;
   logic [31:0] offset;
   logic [2:0]  used_bytes;
   logic        bad_form;

   logic [31:0] regs [8];
   int          total = 0;
   int          bad = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   assign rf_rdata = regs[rf_sel];

   modrm_ea_unit dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .modrm      (modrm),
      .idle       (idle),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .byte_ready (byte_ready),
      .rf_sel     (rf_sel),
      .rf_rdata   (rf_rdata),
      .done       (done),
      .offset     (offset),
      .used_bytes (used_bytes),
      .bad_form   (bad_form)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic expect_op(input logic [7:0] m, input logic [7:0] s, input logic [31:0] d,
                            output logic [31:0] e_off, output int e_cnt, output bit e_bad,
                            output string tag);
      logic [1:0]  md = m[7:6];
      logic [2:0]  rm = m[2:0];
      logic [1:0]  ss = s[7:6];
      logic [2:0]  ix = s[5:3];
      logic [2:0]  bs = s[2:0];
      logic [31:0] base_v;
      logic [31:0] idx_v;
      logic [31:0] disp_v;
      int          len;
      len    = (md == 2'd1) ? 1 : (md == 2'd2) ? 4 : 0;
      base_v = 0;
      idx_v  = 0;
      e_bad  = 1'b0;
      if (md == 2'd3) begin
         e_off = 0; e_cnt = 0; e_bad = 1'b1; tag = "R1";
         return;
      end
      if (rm == 3'd4) begin
         if (md == 2'd0 && bs == 3'd5) begin len = 4; tag = "R5"; end
         else begin base_v = regs[bs]; tag = "R7"; end
         if (ix != 3'd4) idx_v = regs[ix] << ss;
         else begin
            tag = "R6";
            e_bad = (ss != 2'd0);
         end
         e_cnt = 1 + len;
      end else begin
         if (md == 2'd0 && rm == 3'd5) begin len = 4; tag = "R3"; end
         else begin base_v = regs[rm]; tag = "R2"; end
         e_cnt = len;
      end
      disp_v = (len == 1) ? {{24{d[7]}}, d[7:0]} : (len == 4) ? d : 32'd0;
      e_off  = base_v + idx_v + disp_v;
   endtask

   task automatic run_op(input logic [7:0] m, input logic [7:0] s, input logic [31:0] d,
                         input bit gaps, input bit hammer, output logic [31:0] got_off);
      logic [31:0] e_off;
      int          e_cnt;
      bit          e_bad;
      string       tag;
      logic [7:0]  stream [5];
      int          k;
      bit          prev_hs;
      bit          seen;
      int          base;
      expect_op(m, s, d, e_off, e_cnt, e_bad, tag);
      base = (m[7:6] != 2'd3 && m[2:0] == 3'd4) ? 1 : 0;
      stream[0] = base ? s : d[7:0];
      for (int i = 0; i < 4; i++) stream[base + i] = d[i*8 +: 8];
      got_off = 'x;
      @(negedge clk);
      start = 1'b1;
      modrm = m;
      byte_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      k = 0;
      prev_hs = 1'b0;
      seen = 1'b0;
      for (int cyc = 0; cyc < 60; cyc++) begin
         if (prev_hs) k++;
         if (done) begin
            seen = 1'b1;
            start = 1'b0;
            byte_valid = 1'b0;
            got_off = offset;
            check(offset == e_off, tag, "offset", offset, e_off);
            check(used_bytes == 3'(e_cnt), "R11", "used_bytes", 32'(used_bytes), 32'(e_cnt));
            check(bad_form == e_bad, (e_bad && tag != "R1") ? "R6" : "R1", "bad_form",
                  32'(bad_form), 32'(e_bad));
            check(k == e_cnt, base ? "R4" : "R8", "handshakes", 32'(k), 32'(e_cnt));
            break;
         end
         byte_data  = (k < 5) ? stream[k] : 8'hEE;
         byte_valid = gaps ? ((cyc % 3) != 1) : 1'b1;
         prev_hs    = byte_ready && byte_valid;
         if (hammer) begin
            start = !idle;
            modrm = 8'hC4;
         end
         @(negedge clk);
      end
      start = 1'b0;
      byte_valid = 1'b0;
      if (!seen) check(1'b0, tag, "no done (op timeout)", 0, 1);
      @(negedge clk);
      check(done == 1'b0, "R9", "done second cycle", 32'(done), 0);
   endtask

   function automatic logic [31:0] mix(input int n);
      logic [31:0] v;
      v = 32'(n) * 32'h9E37_79B9 + 32'h7F4A_7C15;
      return v ^ (v >> 13);
   endfunction

   initial begin
      logic [31:0] got;
      logic [31:0] held;
      for (int i = 0; i < 8; i++) regs[i] = mix(i + 100) | 32'h8000_0001;
      repeat (3) @(negedge clk);
      check(idle == 1'b1, "R12", "idle in reset", 32'(idle), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(idle == 1'b1, "R12", "idle", 32'(idle), 1);
      check(done == 1'b0, "R12", "done", 32'(done), 0);
      check(byte_ready == 1'b0, "R12", "byte_ready", 32'(byte_ready), 0);
      check(offset == 0, "R12", "offset", offset, 0);
      check(used_bytes == 0, "R12", "used_bytes", 32'(used_bytes), 0);
      check(bad_form == 1'b0, "R12", "bad_form", 32'(bad_form), 0);

      for (int m = 0; m < 256; m++)
         run_op(8'(m), 8'(m) ^ 8'h5A, mix(m), m[0], 1'b0, got);

      for (int md = 0; md < 3; md++)
         for (int s = 0; s < 256; s++)
            run_op({2'(md), 3'b010, 3'b100}, 8'(s), mix(s + 1000 * md), s[1], 1'b0, got);

      run_op(8'h44, 8'h8D, 32'h0000_0080, 1'b0, 1'b0, got);
      check(got == regs[5] + (regs[1] << 2) - 32'd128, "R8", "negative disp8 sign",
            got, regs[5] + (regs[1] << 2) - 32'd128);

      for (int t = 0; t < 4; t++) begin
         logic [7:0] hm;
         hm = (t == 0) ? 8'h84 : (t == 1) ? 8'h05 : (t == 2) ? 8'h43 : 8'hC1;
         run_op(8'h84, 8'(t * 37 + 3), mix(t + 5000), 1'b1, 1'b1, held);
         run_op(hm, 8'(t * 37 + 3), mix(t + 5000), 1'b0, 1'b0, got);
         run_op(8'h84, 8'(t * 37 + 3), mix(t + 5000), 1'b0, 1'b0, got);
         check(got == held, "R10", "start while busy changed result", held, got);
      end

      run_op(8'h8C, 8'h76, 32'h1234_5678, 1'b0, 1'b0, held);
      byte_valid = 1'b1;
      byte_data = 8'hA5;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(offset == held, "R9", "offset hold", offset, held);
         check(byte_ready == 1'b0, "R10", "ready while idle", 32'(byte_ready), 0);
      end
      byte_valid = 1'b0;

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule